// File: doc/BRIEF.md
# Processor Trace Status Encoder

The encoder takes one event per retired instruction from a CPU core and turns it into a real-time trace stream on two 4-bit outputs: a processor-status nibble (`pst`) and a debug-data nibble (`ddata`). Each event always produces a start code. It can also carry up to three optional payloads: a memory source operand, a memory destination operand, and the target address of a taken change-of-flow branch. Each payload that is shown goes out as a size marker on `pst`, followed by its value on `ddata`, one nibble per clock.

Three control pins choose which payloads are shown: memory reads, memory writes and branch targets. Events enter through a valid/ready port. A transfer happens on a rising clock edge where `ev_valid` and `ev_ready` are both high. The producer must hold `ev_valid` and every event field steady until that edge. `ev_ready` is low exactly while the internal event queue is full, and `core_stall` is raised at the same time so the core can pause retirement. No event is ever dropped. The trace outputs have no back-pressure: they advance every clock.

Top module: `trc_encoder`

## Requirements
- R1: Each event begins with exactly one cycle of `pst` = 0x1 with `ddata` = 0x0. An event with no shown payload produces only that cycle.
- R2: A shown operand emits one marker cycle with `ddata` = 0x0. The marker depends on its size code: 2'b00 (1 byte) gives 0x8, 2'b01 (2 bytes) gives 0x9, and 2'b10 or 2'b11 (4 bytes) give 0xB. The marker is followed at once by 2, 4 or 8 cycles of `pst` = 0x0, with `ddata` carrying the value least significant nibble first.
- R3: A branch target is shown only when `ev_cof` and `cfg_show_tgt` are both high. Its length code sets the marker and the number of nibbles that follow: 2'b00 gives 0x9 with 4 nibbles, 2'b01 gives 0xA with 6 nibbles, and 2'b10 or 2'b11 give 0xB with 8 nibbles.
- R4: The source operand is shown only when `ev_src_mem` and `cfg_show_rd` are both high.
- R5: The destination operand is shown only when `ev_dst_mem` and `cfg_show_wr` are both high.
- R6: Within one event the order is: start code, then the source operand, then the destination operand, then the branch target.
- R7: During and after reset, when nothing is pending, `pst` and `ddata` are 0x0. `pst` only ever takes the values 0x0, 0x1, 0x8, 0x9, 0xA and 0xB.
- R8: The queue holds DEPTH events. `ev_ready` is low and `core_stall` is high exactly when DEPTH accepted events are still waiting to start. Every accepted event is emitted.
- R9: Events leave in the order they were accepted, with no gap between them. An event accepted on edge k into an empty, idle block shows its start code after edge k+1. A waiting event shows its start code in the cycle right after the previous event's last cycle.
- R10: The three `cfg_show_*` pins are sampled on the edge where an event's start code is launched. Later changes do not affect that event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_show_rd | input | 1 | Show memory source operands |
| cfg_show_wr | input | 1 | Show memory destination operands |
| cfg_show_tgt | input | 1 | Show branch targets |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Queue can accept an event |
| ev_src_mem | input | 1 | Source operand is a memory reference |
| ev_src_size | input | 2 | Source size code |
| ev_src_data | input | 32 | Source operand value |
| ev_dst_mem | input | 1 | Destination operand is a memory reference |
| ev_dst_size | input | 2 | Destination size code |
| ev_dst_data | input | 32 | Destination operand value |
| ev_cof | input | 1 | Taken change-of-flow branch |
| ev_tgt_len | input | 2 | Target length code |
| ev_tgt_addr | input | 32 | Branch target address |
| core_stall | output | 1 | Request to pause retirement, queue full |
| pst | output | 4 | Processor-status nibble |
| ddata | output | 4 | Debug-data nibble |

## Verification
Two things can land in the same clock edge: a new event arriving at the queue, and the serializer taking the oldest event to launch its start code. The bench provokes this with a long burst of events that carry every payload, offered back to back, so the queue fills and a slot frees while the producer is still waiting. It also sends runs of register-only events, which are taken at one per clock. A behavioural model built from queues predicts `pst`, `ddata`, `ev_ready` and `core_stall` for every cycle, and any mismatch is judged against it. The bench also flips the control pins while an event is waiting, to check the sampling edge.

// File: rtl/trc_pkg.sv
package trc_pkg;
  parameter int TRC_DW = 32;

  localparam logic [3:0] PST_IDLE  = 4'h0;
  localparam logic [3:0] PST_START = 4'h1;

  typedef struct packed {
    logic              src_mem;
    logic [1:0]        src_sz;
    logic [TRC_DW-1:0] src_val;
    logic              dst_mem;
    logic [1:0]        dst_sz;
    logic [TRC_DW-1:0] dst_val;
    logic              cof;
    logic [1:0]        tgt_len;
    logic [TRC_DW-1:0] tgt_val;
  } trc_evt_t;

  function automatic logic [3:0] op_marker(input logic [1:0] sz);
    case (sz)
      2'b00:   return 4'h8;
      2'b01:   return 4'h9;
      default: return 4'hB;
    endcase
  endfunction

  function automatic logic [3:0] op_nibs(input logic [1:0] sz);
    case (sz)
      2'b00:   return 4'd2;
      2'b01:   return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic [3:0] tgt_marker(input logic [1:0] len);
    case (len)
      2'b00:   return 4'h9;
      2'b01:   return 4'hA;
      default: return 4'hB;
    endcase
  endfunction

  function automatic logic [3:0] tgt_nibs(input logic [1:0] len);
    case (len)
      2'b00:   return 4'd4;
      2'b01:   return 4'd6;
      default: return 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/trc_fifo.sv
module trc_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         not_empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLV = CW'(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full      = (cnt_q == FULLV);
  assign not_empty = (cnt_q != '0);
  assign do_push   = push && !full;
  assign do_pop    = pop && not_empty;
  assign rdata     = mem_q[rp_q];

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wp_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/trc_item_mux.sv
module trc_item_mux
  import trc_pkg::*;
(
  input  trc_evt_t          evt,
  input  logic [2:0]        pend,
  output logic [2:0]        pick,
  output logic [3:0]        marker,
  output logic [3:0]        nibs,
  output logic [TRC_DW-1:0] value
);
  localparam int NITEM = 3;

  logic [3:0]        mk_a  [NITEM];
  logic [3:0]        nb_a  [NITEM];
  logic [TRC_DW-1:0] val_a [NITEM];

  // slot 0 source, slot 1 destination, slot 2 target: lowest pending wins
  always_comb begin
    mk_a[0] = op_marker(evt.src_sz);  nb_a[0] = op_nibs(evt.src_sz);  val_a[0] = evt.src_val;
    mk_a[1] = op_marker(evt.dst_sz);  nb_a[1] = op_nibs(evt.dst_sz);  val_a[1] = evt.dst_val;
    mk_a[2] = tgt_marker(evt.tgt_len); nb_a[2] = tgt_nibs(evt.tgt_len); val_a[2] = evt.tgt_val;
  end

  always_comb begin
    pick   = '0;
    marker = PST_IDLE;
    nibs   = '0;
    value  = '0;
    for (int i = NITEM - 1; i >= 0; i--) begin
      if (pend[i]) begin
        pick   = 3'(1 << i);
        marker = mk_a[i];
        nibs   = nb_a[i];
        value  = val_a[i];
      end
    end
  end
endmodule

// File: rtl/trc_serializer.sv
module trc_serializer
  import trc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       show_rd,
  input  logic       show_wr,
  input  logic       show_tgt,
  input  trc_evt_t   head,
  input  logic       head_vld,
  output logic       take,
  output logic [3:0] pst,
  output logic [3:0] ddata
);
  localparam int NIB_MAX = TRC_DW / 4;
  localparam int CNT_W   = $clog2(NIB_MAX + 1);

  typedef enum logic [1:0] {A_IDLE, A_START, A_MARK, A_NIB} act_e;

  trc_evt_t          cur_q;
  logic [2:0]        pend_q;
  logic [TRC_DW-1:0] sh_q;
  logic [CNT_W-1:0]  left_q;
  logic [3:0]        pst_q, dd_q;
  act_e              act;
  logic [2:0]        it_pick;
  logic [3:0]        it_mark, it_nibs;
  logic [TRC_DW-1:0] it_val;
  logic [2:0]        new_pend;

  trc_item_mux u_mux (
    .evt(cur_q), .pend(pend_q), .pick(it_pick),
    .marker(it_mark), .nibs(it_nibs), .value(it_val)
  );

  always_comb begin
    if (left_q != '0)      act = A_NIB;
    else if (pend_q != '0) act = A_MARK;
    else if (head_vld)     act = A_START;
    else                   act = A_IDLE;
  end

  assign take     = (act == A_START);
  assign new_pend = {head.cof & show_tgt, head.dst_mem & show_wr, head.src_mem & show_rd};
  assign pst      = pst_q;
  assign ddata    = dd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      pend_q <= '0;
      sh_q   <= '0;
      left_q <= '0;
      pst_q  <= PST_IDLE;
      dd_q   <= '0;
    end else begin
      case (act)
        A_NIB: begin
          pst_q  <= PST_IDLE;
          dd_q   <= sh_q[3:0];
          sh_q   <= sh_q >> 4;
          left_q <= left_q - 1'b1;
        end
        A_MARK: begin
          pst_q  <= it_mark;
          dd_q   <= '0;
          sh_q   <= it_val;
          left_q <= CNT_W'(it_nibs);
          pend_q <= pend_q & ~it_pick;
        end
        A_START: begin
          pst_q  <= PST_START;
          dd_q   <= '0;
          cur_q  <= head;
          pend_q <= new_pend;
        end
        default: begin
          pst_q <= PST_IDLE;
          dd_q  <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/trc_encoder.sv
module trc_encoder
  import trc_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_show_rd,
  input  logic              cfg_show_wr,
  input  logic              cfg_show_tgt,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic              ev_src_mem,
  input  logic [1:0]        ev_src_size,
  input  logic [TRC_DW-1:0] ev_src_data,
  input  logic              ev_dst_mem,
  input  logic [1:0]        ev_dst_size,
  input  logic [TRC_DW-1:0] ev_dst_data,
  input  logic              ev_cof,
  input  logic [1:0]        ev_tgt_len,
  input  logic [TRC_DW-1:0] ev_tgt_addr,
  output logic              core_stall,
  output logic [3:0]        pst,
  output logic [3:0]        ddata
);
  localparam int EVT_W = $bits(trc_evt_t);

  trc_evt_t in_evt, head_evt;
  logic     full, head_vld, take;

  always_comb begin
    in_evt.src_mem = ev_src_mem;  in_evt.src_sz  = ev_src_size; in_evt.src_val = ev_src_data;
    in_evt.dst_mem = ev_dst_mem;  in_evt.dst_sz  = ev_dst_size; in_evt.dst_val = ev_dst_data;
    in_evt.cof     = ev_cof;      in_evt.tgt_len = ev_tgt_len;  in_evt.tgt_val = ev_tgt_addr;
  end

  trc_fifo #(.W(EVT_W), .DEPTH(DEPTH)) u_q (
    .clk(clk), .rst_n(rst_n),
    .push(ev_valid), .wdata(in_evt),
    .pop(take), .rdata(head_evt),
    .not_empty(head_vld), .full(full)
  );

  trc_serializer u_ser (
    .clk(clk), .rst_n(rst_n),
    .show_rd(cfg_show_rd), .show_wr(cfg_show_wr), .show_tgt(cfg_show_tgt),
    .head(head_evt), .head_vld(head_vld), .take(take),
    .pst(pst), .ddata(ddata)
  );

  assign ev_ready   = !full;
  assign core_stall = full;
endmodule

// File: rtl/trc_encoder_chk.sv
module trc_encoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_valid,
  input logic       ev_ready,
  input logic       core_stall,
  input logic [3:0] pst,
  input logic [3:0] ddata
);
  // R7
  legal_pst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pst inside {4'h0, 4'h1, 4'h8, 4'h9, 4'hA, 4'hB});

  // R1
  quiet_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pst != 4'h0) |-> (ddata == 4'h0));

  // R2
  marker_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pst inside {4'h8, 4'h9, 4'hA, 4'hB}) |=> (pst == 4'h0));

  // R8
  stall_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_stall) |-> $past(ev_valid && ev_ready));
endmodule

bind trc_encoder trc_encoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
  .core_stall(core_stall), .pst(pst), .ddata(ddata)
);

// File: tb/trc_encoder_bench.sv
`timescale 1ns/1ps
module trc_encoder_bench;
  localparam int DEPTH = 4;

  typedef struct {
    bit sm; bit [1:0] ss; bit [31:0] sv;
    bit dm; bit [1:0] ds; bit [31:0] dv;
    bit br; bit [1:0] tl; bit [31:0] tv;
  } ev_t;

  logic clk = 0, rst_n = 0;
  logic cfg_rd = 1, cfg_wr = 1, cfg_tgt = 1;
  logic ev_valid = 0, ev_ready;
  logic src_mem = 0, dst_mem = 0, cof = 0;
  logic [1:0] src_sz = 0, dst_sz = 0, tgt_len = 0;
  logic [31:0] src_d = 0, dst_d = 0, tgt_a = 0;
  logic core_stall;
  logic [3:0] pst, ddata;

  always #2.5 clk = ~clk;

  trc_encoder #(.DEPTH(DEPTH)) u_trc_encoder (
    .clk(clk), .rst_n(rst_n),
    .cfg_show_rd(cfg_rd), .cfg_show_wr(cfg_wr), .cfg_show_tgt(cfg_tgt),
    .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_src_mem(src_mem), .ev_src_size(src_sz), .ev_src_data(src_d),
    .ev_dst_mem(dst_mem), .ev_dst_size(dst_sz), .ev_dst_data(dst_d),
    .ev_cof(cof), .ev_tgt_len(tgt_len), .ev_tgt_addr(tgt_a),
    .core_stall(core_stall), .pst(pst), .ddata(ddata)
  );

  int checks = 0, fails = 0, sent = 0, starts = 0, cyc = 0;
  bit saw_stall = 0;

  ev_t evq[$];
  bit [7:0] symq[$];
  bit [3:0] exp_pst = 0, exp_dd = 0;
  bit exp_full = 0;

  function automatic void add_val(bit [3:0] mk, int n, bit [31:0] v);
    symq.push_back({mk, 4'h0});
    for (int i = 0; i < n; i++) symq.push_back({4'h0, v[4*i +: 4]});
  endfunction

  // behavioural model of the trace stream, one step per clock edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evq.delete(); symq.delete();
      exp_pst = 0; exp_dd = 0; exp_full = 0;
    end else begin
      bit hs;
      bit [7:0] s;
      hs = ev_valid && ev_ready;
      if (symq.size() == 0 && evq.size() != 0) begin
        ev_t e;
        e = evq.pop_front();
        symq.push_back(8'h10);
        if (e.sm && cfg_rd)
          add_val(e.ss == 0 ? 4'h8 : e.ss == 1 ? 4'h9 : 4'hB, e.ss == 0 ? 2 : e.ss == 1 ? 4 : 8, e.sv);
        if (e.dm && cfg_wr)
          add_val(e.ds == 0 ? 4'h8 : e.ds == 1 ? 4'h9 : 4'hB, e.ds == 0 ? 2 : e.ds == 1 ? 4 : 8, e.dv);
        if (e.br && cfg_tgt)
          add_val(e.tl == 0 ? 4'h9 : e.tl == 1 ? 4'hA : 4'hB, e.tl == 0 ? 4 : e.tl == 1 ? 6 : 8, e.tv);
      end
      s = (symq.size() != 0) ? symq.pop_front() : 8'h00;
      exp_pst = s[7:4]; exp_dd = s[3:0];
      if (hs) begin
        ev_t n;
        n.sm = src_mem; n.ss = src_sz; n.sv = src_d;
        n.dm = dst_mem; n.ds = dst_sz; n.dv = dst_d;
        n.br = cof; n.tl = tgt_len; n.tv = tgt_a;
        evq.push_back(n);
      end
      exp_full = (evq.size() == DEPTH);
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      string tag;
      tag = (exp_pst == 1) ? "R1" : (exp_pst == 4'hA) ? "R3" : (exp_pst != 0) ? "R2" :
            (exp_dd != 0) ? "R6" : "R7";
      checks++;
      if (pst !== exp_pst || ddata !== exp_dd) begin
        fails++;
        $display("FAIL %s cyc %0d: pst/ddata %h/%h expected %h/%h", tag, cyc, pst, ddata, exp_pst, exp_dd);
      end
      checks++;
      if (core_stall !== exp_full || ev_ready !== !exp_full) begin
        fails++;
        $display("FAIL R8 cyc %0d: stall/ready %b/%b expected %b/%b", cyc, core_stall, ev_ready, exp_full, !exp_full);
      end
      if (pst == 4'h1) starts++;
      if (core_stall) saw_stall = 1;
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL R9 watchdog expired");
      finish_run();
    end
  end

  task automatic send(bit sm, bit [1:0] ss, bit dm, bit [1:0] ds, bit br, bit [1:0] tl);
    ev_valid = 1;
    src_mem = sm; src_sz = ss; src_d = $urandom;
    dst_mem = dm; dst_sz = ds; dst_d = $urandom;
    cof = br; tgt_len = tl; tgt_a = $urandom;
    while (!ev_ready) @(negedge clk);
    @(negedge clk);
    ev_valid = 0;
    sent++;
  endtask

  task automatic drain();
    while (evq.size() != 0 || symq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset state at the ports
    checks++;
    if (pst !== 0 || ddata !== 0 || core_stall !== 0 || ev_ready !== 1) begin
      fails++;
      $display("FAIL R7 reset: pst %h ddata %h stall %b ready %b expected 0 0 0 1", pst, ddata, core_stall, ev_ready);
    end
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R1: register-only event; R9 latency from an idle block
    send(0, 0, 0, 0, 0, 0);
    drain();
    // R2 R4: each source size code
    for (int k = 0; k < 4; k++) begin send(1, 2'(k), 0, 0, 0, 0); drain(); end
    // R5: each destination size code
    for (int k = 0; k < 4; k++) begin send(0, 0, 1, 2'(k), 0, 0); drain(); end
    // R3: each target length code
    for (int k = 0; k < 4; k++) begin send(0, 0, 0, 0, 1, 2'(k)); drain(); end
    // R6: all three payloads in one event
    send(1, 1, 1, 0, 1, 1);
    drain();

    // R8 R9: back-to-back heavy burst fills the queue while the serializer pops
    for (int k = 0; k < 10; k++) send(1, 2, 1, 2, 1, 2);
    drain();
    checks++;
    if (!saw_stall) begin
      fails++;
      $display("FAIL R8 stall never raised: got 0 expected 1");
    end

    // R9: register-only events leave one per clock, gapless
    for (int k = 0; k < 8; k++) send(0, 0, 0, 0, 0, 0);
    drain();

    // R4: reads only
    cfg_rd = 1; cfg_wr = 0; cfg_tgt = 0;
    send(1, 0, 1, 1, 1, 0); send(0, 0, 1, 2, 1, 1); drain();
    // R5: writes only
    cfg_rd = 0; cfg_wr = 1; cfg_tgt = 0;
    send(1, 1, 1, 0, 1, 2); drain();
    // R3: target only
    cfg_rd = 0; cfg_wr = 0; cfg_tgt = 1;
    send(1, 1, 1, 1, 1, 1); send(1, 1, 1, 1, 0, 1); drain();
    // R1: nothing shown
    cfg_rd = 0; cfg_wr = 0; cfg_tgt = 0;
    send(1, 2, 1, 2, 1, 2); drain();

    // R10: toggle controls while a second event waits behind a long one
    cfg_rd = 1; cfg_wr = 1; cfg_tgt = 1;
    send(1, 2, 1, 2, 1, 2);
    send(1, 2, 1, 2, 1, 2);
    repeat (5) @(negedge clk);
    cfg_wr = 0;
    repeat (12) @(negedge clk);
    cfg_rd = 0; cfg_wr = 1;
    drain();
    cfg_rd = 1; cfg_wr = 1; cfg_tgt = 1;

    // R8 R9: mixed random burst
    for (int k = 0; k < 40; k++)
      send(1'($urandom), 2'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), 2'($urandom));
    drain();

    // R9: every accepted event produced one start code
    checks++;
    if (starts != sent) begin
      fails++;
      $display("FAIL R9 start codes %0d expected %0d", starts, sent);
    end
    finish_run();
  end
endmodule